// File: doc/BRIEF.md
# DMA Channel Arming and Descriptor Loader

This block keeps the armed state of five DMA channels and loads each channel's eight-byte configuration descriptor from memory. Software uses a small byte-wide register port. One register arms or disarms channels. Four more registers hold two 16-bit base pointers, each written as a low and a high byte.

When a channel is armed and has no loaded descriptor, the block computes where that descriptor lives and reads it one byte at a time through a request/grant memory read port. Channel 0 has its own base pointer. Channels 1 to 4 share the second pointer, and their descriptors sit back to back at eight-byte steps. The fetched bytes go into a per-channel slot, and a valid flag is raised once the slot is complete.

Disarming uses the same register as arming, with the top bit of the written byte acting as the abort flag. Aborting a channel drops its descriptor. If that channel's fetch is running, the fetch stops in the same cycle.

Top module: `dma_arm_fetch`

## Requirements
- R1: After reset, no channel is armed, no descriptor is valid, `mem_req` is low, and the arm register reads 0x00.
- R2: A write to register offset 0 with bit 7 clear arms every channel whose bit in bits 4:0 is set and leaves the other channels unchanged. Reading offset 0 returns the armed bits in bits 4:0 and zero in bits 7:5.
- R3: A write to offset 0 with bit 7 set disarms every channel whose bit in bits 4:0 is set and clears that channel's valid flag. The other channels keep their state.
- R4: Byte k of channel 0's descriptor is read at base0 + k. Byte k of channel n (1 to 4) is read at base1 + 8*(n-1) + k. base0 is written through offsets 1 (low byte) and 2 (high byte). base1 is written through offsets 3 (low byte) and 4 (high byte).
- R5: Bytes are requested in the order k = 0 to 7, one byte per cycle in which both `mem_req` and `mem_gnt` are high. The address is held while the request is not granted. `mem_rdata` is taken in the cycle after the grant. Byte k of channel c lands in `desc_data[(c*8+k)*8 +: 8]`. `desc_valid[c]` rises after the eighth byte.
- R6: When several channels are armed without a valid descriptor, they are fetched one at a time, lowest channel number first. A fetch that has started runs to completion before any other channel is served.
- R7: Aborting a channel while its fetch is running removes the request in the cycle of the abort write. No further request is made for that channel, and its valid flag stays clear. Arming it again later fetches all eight bytes from byte 0.
- R8: Arming a channel that is already armed and already holds a valid descriptor starts no memory request.
- R9: Descriptor addresses wrap modulo 2^16.
- R10: Reading offsets 1 to 4 returns the base-pointer bytes last written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read byte address |
| mem_gnt | input | 1 | Memory grant for the current request |
| mem_rdata | input | 8 | Read data, valid the cycle after a grant |
| desc_valid | output | 5 | Per-channel descriptor-loaded flags |
| desc_data | output | 320 | Descriptor slots, 8 bytes per channel |

## Verification
A wrong armed bit shows up on the arm readback in the cycle after the write. It also shows up on the memory port within about two cycles: a fetch that should not happen, or one that is missing. A corrupted byte counter or channel index shows up on the very next granted request as an out-of-sequence address. The scoreboard compares every granted address against its expectation, so such an error is caught when that request occurs. A stuck valid flag or a wrong slot index shows up as a wrong `desc_valid` value or wrong slot bytes as soon as the fetch is expected to be done. The abort cases also watch that the memory port stays silent after the abort.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;
    localparam int BASE_W = 16;
    localparam int ABORT_BIT = 7;

    localparam logic [2:0] REG_ARM  = 3'd0;
    localparam logic [2:0] REG_B0_L = 3'd1;
    localparam logic [2:0] REG_B0_H = 3'd2;
    localparam logic [2:0] REG_B1_L = 3'd3;
    localparam logic [2:0] REG_B1_H = 3'd4;

    typedef enum logic {
        F_IDLE = 1'b0,
        F_BUSY = 1'b1
    } fetch_st_t;
endpackage

// File: rtl/dmaf_regs.sv
module dmaf_regs
    import dmaf_pkg::*;
#(
    parameter int NCH = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [2:0]           rd_addr,
    output logic [7:0]           rd_data,
    output logic [NCH-1:0]       armed,
    output logic [NCH-1:0]       abort_mask,
    output logic [BASE_W-1:0]    base0,
    output logic [BASE_W-1:0]    base1
);
    typedef struct packed {
        logic [NCH-1:0]    armed;
        logic [BASE_W-1:0] base0;
        logic [BASE_W-1:0] base1;
    } regs_t;

    regs_t r_d, r_q;
    logic  arm_wr;

    always_comb begin
        r_d        = r_q;
        arm_wr     = wr_en && (wr_addr == REG_ARM);
        abort_mask = (arm_wr && wr_data[ABORT_BIT]) ? wr_data[NCH-1:0] : '0;
        if (wr_en) begin
            case (wr_addr)
                REG_ARM: begin
                    if (wr_data[ABORT_BIT]) r_d.armed = r_q.armed & ~wr_data[NCH-1:0];
                    else                    r_d.armed = r_q.armed | wr_data[NCH-1:0];
                end
                REG_B0_L: r_d.base0[7:0]  = wr_data;
                REG_B0_H: r_d.base0[15:8] = wr_data;
                REG_B1_L: r_d.base1[7:0]  = wr_data;
                REG_B1_H: r_d.base1[15:8] = wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            REG_ARM:  rd_data = {{(8-NCH){1'b0}}, r_q.armed};
            REG_B0_L: rd_data = r_q.base0[7:0];
            REG_B0_H: rd_data = r_q.base0[15:8];
            REG_B1_L: rd_data = r_q.base1[7:0];
            REG_B1_H: rd_data = r_q.base1[15:8];
            default:  rd_data = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign armed = r_q.armed;
    assign base0 = r_q.base0;
    assign base1 = r_q.base1;
endmodule

// File: rtl/dmaf_fetch.sv
module dmaf_fetch
    import dmaf_pkg::*;
#(
    parameter int NCH        = 5,
    parameter int DESC_BYTES = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int IW = $clog2(DESC_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    need,
    input  logic [NCH-1:0]    abort_mask,
    input  logic [BASE_W-1:0] base0,
    input  logic [BASE_W-1:0] base1,
    output logic              mem_req,
    output logic [BASE_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic [7:0]        mem_rdata,
    output logic              st_we,
    output logic [CW-1:0]     st_ch,
    output logic [IW-1:0]     st_idx,
    output logic [7:0]        st_byte,
    output logic              st_done
);
    typedef struct packed {
        fetch_st_t   st;
        logic [CW-1:0] ch;
        logic [IW:0]   issue;
        logic          fly;
        logic [IW-1:0] fly_idx;
    } fetch_t;

    fetch_t f_d, f_q;
    logic            kill;
    logic [NCH-1:0]  cand;
    logic [CW-1:0]   pick;
    logic [BASE_W-1:0] chan_off;
    logic [BASE_W-1:0] chan_base;

    always_comb begin
        f_d  = f_q;
        f_d.fly = 1'b0;
        kill = (f_q.st == F_BUSY) && abort_mask[f_q.ch];

        chan_off  = BASE_W'((int'(f_q.ch) - 1) * DESC_BYTES);
        chan_base = (f_q.ch == '0) ? base0 : base1 + chan_off;
        mem_addr  = chan_base + BASE_W'(f_q.issue);
        mem_req   = (f_q.st == F_BUSY) && (f_q.issue < (IW+1)'(DESC_BYTES)) && !kill;

        st_we   = f_q.fly && !kill;
        st_ch   = f_q.ch;
        st_idx  = f_q.fly_idx;
        st_byte = mem_rdata;
        st_done = st_we && (f_q.fly_idx == IW'(DESC_BYTES - 1));

        cand = need & ~abort_mask;
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) pick = CW'(i);
        end

        case (f_q.st)
            F_IDLE: begin
                if (|cand) begin
                    f_d.st    = F_BUSY;
                    f_d.ch    = pick;
                    f_d.issue = '0;
                end
            end
            default: begin
                if (kill) begin
                    f_d.st = F_IDLE;
                end else begin
                    if (mem_req && mem_gnt) begin
                        f_d.issue   = f_q.issue + 1'b1;
                        f_d.fly     = 1'b1;
                        f_d.fly_idx = f_q.issue[IW-1:0];
                    end
                    if (st_done) f_d.st = F_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: F_IDLE, default: '0};
        else        f_q <= f_d;
    end
endmodule

// File: rtl/dmaf_store.sv
module dmaf_store #(
    parameter int NCH        = 5,
    parameter int DESC_BYTES = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int IW = $clog2(DESC_BYTES),
    localparam int SW = NCH * DESC_BYTES * 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           st_we,
    input  logic [CW-1:0]  st_ch,
    input  logic [IW-1:0]  st_idx,
    input  logic [7:0]     st_byte,
    input  logic           st_done,
    input  logic [NCH-1:0] clear_mask,
    output logic [NCH-1:0] valid,
    output logic [SW-1:0]  slots
);
    typedef struct packed {
        logic [NCH-1:0] valid;
        logic [SW-1:0]  data;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (st_we) begin
            s_d.data[(int'(st_ch) * DESC_BYTES + int'(st_idx)) * 8 +: 8] = st_byte;
        end
        if (st_done) s_d.valid[st_ch] = 1'b1;
        s_d.valid = s_d.valid & ~clear_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = s_q.valid;
    assign slots = s_q.data;
endmodule

// File: rtl/dma_arm_fetch.sv
module dma_arm_fetch
    import dmaf_pkg::*;
#(
    parameter int NCH        = 5,
    parameter int DESC_BYTES = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int IW = $clog2(DESC_BYTES),
    localparam int SW = NCH * DESC_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [2:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              mem_req,
    output logic [BASE_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic [7:0]        mem_rdata,
    output logic [NCH-1:0]    desc_valid,
    output logic [SW-1:0]     desc_data
);
    logic [NCH-1:0]    armed;
    logic [NCH-1:0]    abort_mask;
    logic [BASE_W-1:0] base0, base1;
    logic              st_we, st_done;
    logic [CW-1:0]     st_ch;
    logic [IW-1:0]     st_idx;
    logic [7:0]        st_byte;

    dmaf_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .armed(armed), .abort_mask(abort_mask),
        .base0(base0), .base1(base1)
    );

    dmaf_fetch #(.NCH(NCH), .DESC_BYTES(DESC_BYTES)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .need(armed & ~desc_valid), .abort_mask(abort_mask),
        .base0(base0), .base1(base1),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .st_we(st_we), .st_ch(st_ch), .st_idx(st_idx),
        .st_byte(st_byte), .st_done(st_done)
    );

    dmaf_store #(.NCH(NCH), .DESC_BYTES(DESC_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .st_we(st_we), .st_ch(st_ch), .st_idx(st_idx),
        .st_byte(st_byte), .st_done(st_done),
        .clear_mask(abort_mask),
        .valid(desc_valid), .slots(desc_data)
    );
endmodule

// File: rtl/dmaf_chk.sv
module dmaf_chk
    import dmaf_pkg::*;
#(
    parameter int NCH = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [BASE_W-1:0] mem_addr,
    input logic [NCH-1:0]    armed,
    input logic [NCH-1:0]    desc_valid
);
    logic arm_wr, abort_wr;
    assign arm_wr   = wr_en && (wr_addr == REG_ARM);
    assign abort_wr = arm_wr && wr_data[ABORT_BIT];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        a_r2_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_wr && !wr_data[ABORT_BIT] && wr_data[i]) |=> armed[i]);

        a_r3_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (abort_wr && wr_data[i]) |=> (!armed[i] && !desc_valid[i]));

        a_r3_valid_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
            desc_valid[i] |-> armed[i]);
    end

    // R7: a request only exists for an armed channel
    a_r7_req_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (armed != '0));

    // R5: an ungranted request holds its address unless an abort intervenes
    a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !abort_wr) |=> ((mem_req && $stable(mem_addr)) || abort_wr));
endmodule

bind dma_arm_fetch dmaf_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_dma_arm_fetch.sv
`timescale 1ns/1ps
module sim_dma_arm_fetch;
    localparam int NCH = 5;
    localparam int DB  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_gnt = 1'b1;
    logic [7:0]  mem_rdata = '0;
    logic [NCH-1:0] desc_valid;
    logic [NCH*DB*8-1:0] desc_data;

    int n_chk = 0;
    int n_fail = 0;
    bit gnt_rand = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] exp_q[$];
    logic [15:0] b0 = '0, b1 = '0;
    logic [15:0] slot_base [NCH];

    always #10 clk = ~clk;

    dma_arm_fetch u0 (.*);

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #2 mem_gnt = gnt_rand ? lfsr[0] : 1'b1;
    end

    always @(posedge clk) begin
        logic [15:0] a;
        if (mem_req && mem_gnt) begin
            a = mem_addr;
            #1 mem_rdata = mem_byte(a);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every granted request must match the next expected address
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_gnt) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8/R7 unexpected request", {16'h0, mem_addr}, 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(mem_addr == e, "R4/R5/R6/R9 request address", {16'h0, mem_addr}, {16'h0, e});
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #4;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #4;
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic push_desc(input int ch);
        logic [15:0] base;
        base = (ch == 0) ? b0 : 16'(b1 + 16'(DB * (ch - 1)));
        slot_base[ch] = base;
        for (int k = 0; k < DB; k++) exp_q.push_back(16'(base + 16'(k)));
    endtask

    task automatic wait_drain();
        for (int t = 0; t < 600 && exp_q.size() != 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all bytes requested", exp_q.size(), 0);
    endtask

    task automatic check_slot(input int ch);
        for (int k = 0; k < DB; k++) begin
            logic [7:0] got, want;
            got  = desc_data[(ch * DB + k) * 8 +: 8];
            want = mem_byte(16'(slot_base[ch] + 16'(k)));
            chk(got == want, "R5 slot byte", {24'h0, got}, {24'h0, want});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(3'd0, r);
        chk(r == 8'h00, "R1 arm readback", r, 0);
        chk(desc_valid == '0, "R1 valid", desc_valid, 0);
        chk(mem_req == 1'b0, "R1 no request", mem_req, 0);

        // R10 base registers
        b0 = 16'h1200; b1 = 16'h3400;
        reg_write(3'd1, 8'h00); reg_write(3'd2, 8'h12);
        reg_write(3'd3, 8'h00); reg_write(3'd4, 8'h34);
        reg_read(3'd2, r); chk(r == 8'h12, "R10 base0 high", r, 8'h12);
        reg_read(3'd4, r); chk(r == 8'h34, "R10 base1 high", r, 8'h34);

        // R2 arm channels 0 and 1
        push_desc(0); push_desc(1);
        reg_write(3'd0, 8'h03);
        reg_read(3'd0, r); chk(r == 8'h03, "R2 arm readback", r, 8'h03);
        wait_drain();
        chk(desc_valid == 5'h03, "R5 valid after fetch", desc_valid, 5'h03);
        check_slot(0); check_slot(1);

        // R3 abort channel 0, channel 1 stays
        reg_write(3'd0, 8'h81);
        reg_read(3'd0, r); chk(r == 8'h02, "R3 abort readback", r, 8'h02);
        chk(desc_valid == 5'h02, "R3 valid cleared", desc_valid, 5'h02);

        // R8 re-arm of armed+valid channel: no fetch
        reg_write(3'd0, 8'h02);
        repeat (30) @(negedge clk);
        chk(desc_valid == 5'h02, "R8 valid unchanged", desc_valid, 5'h02);

        // R6 several channels at once, random grants, lowest first
        gnt_rand = 1;
        push_desc(2); push_desc(3); push_desc(4);
        reg_write(3'd0, 8'h1C);
        wait_drain();
        chk(desc_valid == 5'h1E, "R6 valid set", desc_valid, 5'h1E);
        check_slot(2); check_slot(3); check_slot(4);
        gnt_rand = 0;

        // R6 running fetch is not preempted by a lower channel
        reg_write(3'd0, 8'h9F);
        reg_read(3'd0, r); chk(r == 8'h00, "R3 abort all", r, 0);
        push_desc(4);
        reg_write(3'd0, 8'h10);
        repeat (2) @(negedge clk);
        push_desc(0);
        reg_write(3'd0, 8'h01);
        wait_drain();
        chk(desc_valid == 5'h11, "R6 both fetched", desc_valid, 5'h11);
        check_slot(4); check_slot(0);

        // R7 abort in the middle of a fetch
        push_desc(2);
        reg_write(3'd0, 8'h04);
        repeat (3) @(negedge clk);
        chk(exp_q.size() > 0 && exp_q.size() < DB, "R7 abort lands mid-fetch", exp_q.size(), 4);
        @(posedge clk); #4;
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h84;
        @(negedge clk);
        chk(mem_req == 1'b0, "R7 request dropped at abort", mem_req, 0);
        exp_q.delete();
        @(posedge clk); #4;
        wr_en = 1'b0;
        repeat (20) @(negedge clk);
        chk(desc_valid[2] == 1'b0, "R7 valid stays clear", desc_valid[2], 0);
        reg_read(3'd0, r); chk(r == 8'h11, "R7 channel disarmed", r, 8'h11);

        // R7 re-arm fetches from byte 0
        push_desc(2);
        reg_write(3'd0, 8'h04);
        wait_drain();
        chk(desc_valid[2] == 1'b1, "R7 refetch valid", desc_valid[2], 1);
        check_slot(2);

        // R9 wrap-around of descriptor address
        b1 = 16'hFFF0;
        reg_write(3'd3, 8'hF0); reg_write(3'd4, 8'hFF);
        reg_write(3'd0, 8'h88);
        push_desc(3);
        reg_write(3'd0, 8'h08);
        wait_drain();
        chk(slot_base[3] == 16'h0000, "R9 wrapped base", slot_base[3], 0);
        chk(desc_valid[3] == 1'b1, "R9 valid", desc_valid[3], 1);
        check_slot(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule